// File: doc/BRIEF.md
# Status-Augmented Interrupt Vector Register

This block holds the interrupt vector that a processor fetches when it services a UART-emulation peripheral. The processor writes the vector over its bus and reads it back. A mode input, `vis`, sets how a read is formed. With `vis` low the read returns the stored byte unchanged. With `vis` high the read merges the stored upper nibble with a 3-bit code. The code names the highest-priority pending source that is not already being serviced, and bit 0 reads as 0.

Seven request lines feed a priority encoder. Each line has an in-service flag. A request whose flag is set is hidden from the encoder and from the request output. An acknowledge strobe marks the source that is currently encoded as in service. A per-source clear input ends that service. The status field is not latched, so it follows the live request lines. A read that comes after an acknowledge can therefore report a newer source whose flag is still clear.

Top module: `ivec_status_reg`

## Requirements
- R1: With `vis`=0 and `rd_en`=1, `rd_data` equals all 8 bits of the last write, bit 0 included.
- R2: With `vis`=1, `rd_en`=1 and a source pending, `rd_data[7:4]` holds the written upper nibble and `rd_data[3:1]` holds the code of the winning source. Request line k (0..6) has code k+1:
  - 1 = FIFO-control write or transmit overrun
  - 2 = divisor write
  - 3 = line-control write
  - 4 = modem-control write
  - 5 = receive buffer
  - 6 = transmit timeout
  - 7 = transmit holding register
- R3: With `vis`=1, `rd_data[0]` reads 0.
- R4: With `vis`=1, `rd_en`=1 and nothing pending, `rd_data` equals the written bits 7:1 with bit 0 cleared.
- R5: When several sources are pending, the highest code wins. The status field follows the request lines in the same cycle, with no latching.
- R6: An `ack` pulse sets, at the next clock edge, the in-service flag of the source encoded in that cycle. An `ack` with nothing pending changes no flag.
- R7: A source whose in-service flag is set is left out of the encoder and out of `irq`.
- R8: `ius_clr[k]` clears flag k at the next clock edge. It takes precedence over a set caused by `ack` in the same cycle.
- R9: `irq` is 1 exactly when some request line is high and its in-service flag is 0.
- R10: Reset clears the stored vector and all in-service flags. `rd_data` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Vector value written |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 8 | Vector as read |
| vis | input | 1 | 1 = splice status into the vector |
| irq_req | input | 7 | Request lines, line k has code k+1 |
| ack | input | 1 | Interrupt-acknowledge strobe |
| ius_clr | input | 7 | Per-source in-service clear |
| ius | output | 7 | In-service flags |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions check the following on every cycle:
- bit 0 reads 0 in status mode;
- the spliced code matches the encoder;
- the encoder picks only a line that is high and not in service;
- `irq` agrees with the encoder;
- each in-service flag follows the acknowledge and clear rules.

The bench scenarios are what show the full byte values read in both modes. They also show that the highest code wins when requests overlap. Finally, they show that after an acknowledge a later read moves on to the next live source, and that the clear restores the masked one.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int IVEC_NSRC = 7;
  localparam int IVEC_HI_W = 4;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_FCTL    = 3'd1,
    SRC_DIVISOR = 3'd2,
    SRC_LINE    = 3'd3,
    SRC_MODEM   = 3'd4,
    SRC_RXBUF   = 3'd5,
    SRC_TXTMO   = 3'd6,
    SRC_TXHOLD  = 3'd7
  } ivec_src_e;
endpackage

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
  parameter int NSRC = ivec_pkg::IVEC_NSRC,
  localparam int CODE_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]   live,
  output logic [CODE_W-1:0] code
);
  function automatic logic [CODE_W-1:0] top_code(input logic [NSRC-1:0] m);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++)
      if (m[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  always_comb code = top_code(live);
endmodule

// File: rtl/ivec_ius_bank.sv
module ivec_ius_bank #(
  parameter int NSRC = ivec_pkg::IVEC_NSRC,
  localparam int CODE_W = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic [CODE_W-1:0] code,
  input  logic [NSRC-1:0]   clr,
  output logic [NSRC-1:0]   ius
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic hit;
    assign hit = ack && (code == CODE_W'(i + 1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ius[i] <= 1'b0;
      else if (clr[i]) ius[i] <= 1'b0;
      else if (hit)    ius[i] <= 1'b1;

    assert_ack_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr[i]) |=> ius[i]);
    assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !ius[i]);
    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ius[i] && !hit) |=> !ius[i]);
  end
endmodule

// File: rtl/ivec_status_reg.sv
module ivec_status_reg #(
  parameter int NSRC = ivec_pkg::IVEC_NSRC,
  parameter int HI_W = ivec_pkg::IVEC_HI_W,
  localparam int CODE_W = $clog2(NSRC + 1),
  localparam int DW = HI_W + CODE_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  input  logic            vis,
  input  logic [NSRC-1:0] irq_req,
  input  logic            ack,
  input  logic [NSRC-1:0] ius_clr,
  output logic [NSRC-1:0] ius,
  output logic            irq
);
  logic [DW-1:0]     vec_q;
  logic [NSRC-1:0]   live;
  logic [CODE_W-1:0] code;

  function automatic logic [DW-1:0] read_view(input logic rd, input logic mode,
                                              input logic [DW-1:0] v,
                                              input logic [CODE_W-1:0] c);
    if (!rd)          return '0;
    if (!mode)        return v;
    if (c != '0)      return {v[DW-1 -: HI_W], c, 1'b0};
    return {v[DW-1:1], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     vec_q <= '0;
    else if (wr_en) vec_q <= wr_data;

  assign live = irq_req & ~ius;
  assign irq  = |live;

  ivec_prio_enc #(.NSRC(NSRC)) u_enc (.live(live), .code(code));

  ivec_ius_bank #(.NSRC(NSRC)) u_ius (
    .clk(clk), .rst_n(rst_n), .ack(ack), .code(code), .clr(ius_clr), .ius(ius)
  );

  always_comb rd_data = read_view(rd_en, vis, vec_q, code);

  assert_write_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vec_q == $past(wr_data));
  assert_bit0_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && vis) |-> !rd_data[0]);
  assert_code_spliced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && vis && code != '0) |-> rd_data[CODE_W:1] == code);
  assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_enc_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (code == CODE_W'(i + 1)) |-> (irq_req[i] && !ius[i]));
    assert_enc_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code == CODE_W'(i + 1)) |-> ((irq_req & ~ius) >> (i + 1)) == '0);
  end
endmodule

// File: tb/sim_ivec_status_reg.sv
`timescale 1ns/100ps
module sim_ivec_status_reg;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, vis = 0, ack = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] irq_req = 0, ius_clr = 0;
  logic [7:0] rd_data;
  logic [6:0] ius;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_vec = 0;
  logic [6:0] m_ius = 0;

  always #2.5 clk = ~clk;

  ivec_status_reg u0 (.clk, .rst_n, .wr_en, .wr_data, .rd_en, .rd_data, .vis,
                      .irq_req, .ack, .ius_clr, .ius, .irq);

  function automatic logic [2:0] best(input logic [6:0] req, input logic [6:0] f);
    logic [6:0] m = req & ~f;
    for (int k = 6; k >= 0; k--) if (m[k]) return 3'(k + 1);
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic r, input logic v, input logic [7:0] vec,
                                        input logic [2:0] c);
    if (!r) return 8'h00;
    if (!v) return vec;
    if (c != 0) return {vec[7:4], c, 1'b0};
    return vec & 8'hFE;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_all(input string tag);
    logic [2:0] c = best(irq_req, m_ius);
    chk({tag, " rd_data"}, rd_data, exp_rd(rd_en, vis, m_vec, c));
    chk("R9 irq", {7'd0, irq}, {7'd0, c != 0});
    chk("R6 R8 ius", {1'b0, ius}, {1'b0, m_ius});
  endtask

  task automatic model_edge();
    logic [2:0] c = best(irq_req, m_ius);
    logic [6:0] nx = m_ius;
    if (ack && c != 0) nx[c-1] = 1'b1;
    nx &= ~ius_clr;
    m_ius = nx;
    if (wr_en) m_vec = wr_data;
  endtask

  task automatic step(input string tag);
    #1;
    check_all(tag);
    model_edge();
    @(negedge clk);
    wr_en = 0; ack = 0; ius_clr = 0;
  endtask

  initial begin
    process_watch();
  end

  task automatic process_watch();
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1C5A);
    repeat (2) @(negedge clk);
    rd_en = 1; vis = 0;
    #1;
    chk("R10 reset rd_data", rd_data, 8'h00);
    chk("R10 reset ius", {1'b0, ius}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    wr_en = 1; wr_data = 8'hA5; step("R1 write");
    rd_en = 1; vis = 0; #1; chk("R1 plain readback", rd_data, 8'hA5);
    vis = 1; #1; chk("R4 R3 no pending", rd_data, 8'hA4);
    rd_en = 0; #1; chk("R10 idle read", rd_data, 8'h00);
    rd_en = 1; irq_req = 7'b0100010; #1;
    chk("R2 R5 code 6 wins", rd_data, 8'hAC);
    chk("R9 irq up", {7'd0, irq}, 8'h01);
    irq_req = 7'b1000000; #1; chk("R5 live follow code 7", rd_data, 8'hAE);
    irq_req = 7'b0100010; ack = 1; step("R6 ack");
    chk("R6 flag 6 set", {1'b0, ius}, 8'h20);
    #1; chk("R7 masked, code 2", rd_data, 8'hA4);
    irq_req = 7'b0100000; #1;
    chk("R7 irq masked", {7'd0, irq}, 8'h00);
    chk("R4 masked read", rd_data, 8'hA4);
    ack = 1; step("R6 ack none");
    chk("R6 empty ack", {1'b0, ius}, 8'h20);
    irq_req = 7'b0000001; ack = 1; ius_clr = 7'b0000001; step("R8 clr vs ack");
    chk("R8 clear wins", {1'b0, ius}, 8'h20);
    ius_clr = 7'b0100000; step("R8 clr");
    chk("R8 cleared", {1'b0, ius}, 8'h00);
    irq_req = 7'b0100000; #1; chk("R2 code 6 back", rd_data, 8'hAC);
    vis = 0; #1; chk("R1 vis off", rd_data, 8'hA5);
    for (int n = 0; n < 3000; n++) begin
      wr_en   = ($urandom % 6) == 0;
      wr_data = 8'($urandom);
      rd_en   = ($urandom % 5) != 0;
      vis     = $urandom % 2;
      irq_req = 7'($urandom & $urandom);
      ack     = ($urandom % 4) == 0;
      ius_clr = 7'($urandom & $urandom & $urandom);
      step("R2 R5 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule